// File: doc/BRIEF.md
# Video Memory Column Arbiter

This block sits between one shared video memory, a display fetch engine and an 8-bit CPU. Every scan line is cut into fixed-length columns of master clocks. The first part of each column is reserved for the display engine, as back-to-back fetch slots. The tail of the column is the only window in which the CPU may reach the memory. The block owns the single memory port and steers it to one side or the other according to the column phase. It also publishes the phase, the column number and a line-start pulse, so the display engine knows when to present each fetch address.

The CPU is never given wait states. When it addresses a page marked as video memory, the block freezes it by pulling its clock enable low. The enable stays low until a CPU window can hold the whole access, and then for the length of that access. Pages that are not marked as video never stall the CPU. The page marking comes from an input vector with one bit per page, indexed by the top address bits.

The CPU side is a small state machine with four states. GATE_IDLE means no access is in progress. GATE_HOLD means a video access is waiting for a window. GATE_ACCESS means the CPU owns the port. GATE_RELEASE is the one cycle in which the CPU is let run and collects its data. Its transitions are:
- start: GATE_IDLE or GATE_HOLD to GATE_ACCESS, when the next phase lies in the legal start range.
- defer: GATE_IDLE to GATE_HOLD, when the next phase does not lie in that range.
- withdraw: GATE_HOLD to GATE_IDLE, when the video request disappears.
- step: GATE_ACCESS to itself, while the access counter runs.
- finish: GATE_ACCESS to GATE_RELEASE, on the last access clock.
- resume: GATE_RELEASE to GATE_IDLE.

Top module: `vram_contention_arbiter`

## Requirements
- R1: `col_phase` counts 0 to COL_CLKS-1 (default 16) and wraps to 0. `col_idx` advances when the phase wraps and runs 0 to COLS_PER_LINE-1 (default 57) before wrapping. `line_start` is high exactly in the cycle where both are 0.
- R2: In every cycle in which the CPU is not granted, including all fetch phases 0 to FETCH_CLKS*NUM_FETCH-1 (default 0 to 9), `mem_addr` equals `disp_addr`, `mem_we` is 0 and `mem_wdata` is 0.
- R3: Fetch slot i covers phases i*FETCH_CLKS to (i+1)*FETCH_CLKS-1. `mem_rdata` is captured at the end of the slot's last phase. In the next cycle (phases 5 and 10 by default), `disp_valid` is high for one cycle, `disp_rdata` holds the captured byte and `disp_slot` holds i (0 for the first slot, 1 for the second).
- R4: The page of a CPU address is its top PAGE_W bits (default bits 15:14). A request is a video request when `page_sel[page]` is 1.
- R5: A CPU request to a non-video page leaves `cpu_clk_en` at 1 in every cycle and never drives `mem_we`.
- R6: A video request first seen in phase p pulls `cpu_clk_en` low in that same cycle. The access starts in the following phase if that phase lies between 10 and COL_CLKS-CPU_ACC_CLKS (default 13). Otherwise it starts at phase 10.
- R7: The access holds the port for CPU_ACC_CLKS clocks (default 3), with `mem_addr`=`cpu_addr`, `mem_we`=`cpu_we` and `mem_wdata`=`cpu_wdata`. Read data is captured at the end of the last access clock. `cpu_clk_en` is 1 in the next cycle, with `cpu_rdata` valid.
- R8: No access starts after phase COL_CLKS-CPU_ACC_CLKS. Such a request waits for phase 10 of the next column, so a CPU grant never covers a fetch phase.
- R9: After reset, phase and column are 0, `line_start` is 1, `disp_valid` is 0 and `cpu_clk_en` is 1 while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_sel | input | 2**PAGE_W | One bit per page; 1 marks a video page |
| cpu_req | input | 1 | CPU memory request |
| cpu_we | input | 1 | CPU write when 1 |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data, valid when the enable returns |
| cpu_clk_en | output | 1 | CPU clock enable; 0 freezes the CPU |
| disp_addr | input | ADDR_W | Display fetch address |
| disp_rdata | output | DATA_W | Byte from the last completed fetch slot |
| disp_valid | output | 1 | One-cycle strobe per completed fetch slot |
| disp_slot | output | SLOT_W | Index of the slot that produced `disp_rdata` |
| col_phase | output | PH_W | Clock position inside the column |
| col_idx | output | COL_W | Column number inside the line |
| line_start | output | 1 | High in phase 0 of column 0 |
| mem_addr | output | ADDR_W | Shared memory address |
| mem_we | output | 1 | Shared memory write enable |
| mem_wdata | output | DATA_W | Shared memory write data |
| mem_rdata | input | DATA_W | Shared memory read data, combinational on `mem_addr` |

## Verification
The bench keeps the default column geometry: 16 clocks, two 5-clock fetch slots and a 3-clock CPU access. It shortens the line to 4 columns, so that several complete line wraps of `col_idx` and `line_start` fit in a short run. With that geometry the stall count can be predicted for each request phase. This covers the latest legal start at phase 13 (where the enable returns in the next column's phase 0) and the deferral of requests made at phases 13 and 15. The bench also remaps `page_sel` to show that the same low address switches between stalling and free running.

// File: rtl/vca_pkg.sv
package vca_pkg;

    typedef enum logic [1:0] {
        GATE_IDLE,
        GATE_HOLD,
        GATE_ACCESS,
        GATE_RELEASE
    } gate_state_t;

endpackage

// File: rtl/vca_column_timer.sv
module vca_column_timer #(
    parameter int COL_CLKS      = 16,
    parameter int COLS_PER_LINE = 57,
    localparam int PH_W  = $clog2(COL_CLKS),
    localparam int COL_W = (COLS_PER_LINE > 1) ? $clog2(COLS_PER_LINE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PH_W-1:0]  phase,
    output logic [COL_W-1:0] col,
    output logic             line_start
);

    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(COL_CLKS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS_PER_LINE - 1);

    // phase ticks every clock; the column moves on when the phase wraps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            col   <= '0;
        end else if (phase == PH_LAST) begin
            phase <= '0;
            col   <= (col == COL_LAST) ? '0 : col + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign line_start = (phase == '0) && (col == '0);

endmodule

// File: rtl/vca_page_decode.sv
module vca_page_decode #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 2,
    localparam int NPAGES = 1 << PAGE_W
) (
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [NPAGES-1:0] page_sel,
    output logic              video_req
);

    logic [PAGE_W-1:0] page;

    assign page      = cpu_addr[ADDR_W-1 -: PAGE_W];
    assign video_req = cpu_req && page_sel[page];

endmodule

// File: rtl/vca_fetch_capture.sv
module vca_fetch_capture #(
    parameter int COL_CLKS   = 16,
    parameter int FETCH_CLKS = 5,
    parameter int NUM_FETCH  = 2,
    parameter int DATA_W     = 8,
    localparam int PH_W   = $clog2(COL_CLKS),
    localparam int SLOT_W = (NUM_FETCH > 1) ? $clog2(NUM_FETCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] disp_rdata,
    output logic              disp_valid,
    output logic [SLOT_W-1:0] disp_slot
);

    logic [NUM_FETCH-1:0] slot_end;
    logic                 end_hit;
    logic [SLOT_W-1:0]    end_idx;

    // one comparator per fetch slot: its last phase
    for (genvar i = 0; i < NUM_FETCH; i++) begin : g_slot
        assign slot_end[i] = (phase == PH_W'((i + 1) * FETCH_CLKS - 1));
    end

    always_comb begin
        end_hit = 1'b0;
        end_idx = '0;
        for (int i = 0; i < NUM_FETCH; i++) begin
            if (slot_end[i]) begin
                end_hit = 1'b1;
                end_idx = SLOT_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid <= 1'b0;
            disp_rdata <= '0;
            disp_slot  <= '0;
        end else begin
            disp_valid <= end_hit;
            if (end_hit) begin
                disp_rdata <= mem_rdata;
                disp_slot  <= end_idx;
            end
        end
    end

endmodule

// File: rtl/vca_cpu_gate.sv
module vca_cpu_gate
    import vca_pkg::*;
#(
    parameter int COL_CLKS     = 16,
    parameter int WIN_START    = 10,
    parameter int CPU_ACC_CLKS = 3,
    localparam int PH_W  = $clog2(COL_CLKS),
    localparam int CNT_W = (CPU_ACC_CLKS > 1) ? $clog2(CPU_ACC_CLKS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  logic            video_req,
    output logic            grant,
    output logic            capture,
    output logic            clk_en
);

    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(COL_CLKS - 1);
    localparam logic [PH_W-1:0]  WIN_S    = PH_W'(WIN_START);
    localparam logic [PH_W-1:0]  LAST_S   = PH_W'(COL_CLKS - CPU_ACC_CLKS);
    localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(CPU_ACC_CLKS - 1);

    gate_state_t      state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [PH_W-1:0]  ph_next;
    logic             start_ok;

    // the access occupies the phases starting at ph_next
    assign ph_next  = (phase == PH_LAST) ? '0 : phase + 1'b1;
    assign start_ok = (ph_next >= WIN_S) && (ph_next <= LAST_S);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GATE_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            GATE_IDLE: begin
                if (video_req) begin
                    if (start_ok) begin
                        state_nxt = GATE_ACCESS;
                        cnt_nxt   = '0;
                    end else begin
                        state_nxt = GATE_HOLD;
                    end
                end
            end
            GATE_HOLD: begin
                if (!video_req) begin
                    state_nxt = GATE_IDLE;
                end else if (start_ok) begin
                    state_nxt = GATE_ACCESS;
                    cnt_nxt   = '0;
                end
            end
            GATE_ACCESS: begin
                if (cnt == ACC_LAST) begin
                    state_nxt = GATE_RELEASE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            GATE_RELEASE: begin
                state_nxt = GATE_IDLE;
            end
            default: state_nxt = GATE_IDLE;
        endcase
    end

    always_comb begin
        grant   = 1'b0;
        capture = 1'b0;
        clk_en  = 1'b1;
        unique case (state)
            GATE_IDLE, GATE_HOLD: begin
                clk_en = !video_req;
            end
            GATE_ACCESS: begin
                grant   = 1'b1;
                clk_en  = 1'b0;
                capture = (cnt == ACC_LAST);
            end
            GATE_RELEASE: begin
                clk_en = 1'b1;
            end
            default: clk_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/vram_contention_arbiter.sv
module vram_contention_arbiter #(
    parameter int COL_CLKS      = 16,
    parameter int FETCH_CLKS    = 5,
    parameter int NUM_FETCH     = 2,
    parameter int COLS_PER_LINE = 57,
    parameter int CPU_ACC_CLKS  = 3,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int PAGE_W        = 2,
    localparam int PH_W      = $clog2(COL_CLKS),
    localparam int COL_W     = (COLS_PER_LINE > 1) ? $clog2(COLS_PER_LINE) : 1,
    localparam int NPAGES    = 1 << PAGE_W,
    localparam int SLOT_W    = (NUM_FETCH > 1) ? $clog2(NUM_FETCH) : 1,
    localparam int WIN_START = FETCH_CLKS * NUM_FETCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPAGES-1:0] page_sel,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_clk_en,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic [DATA_W-1:0] disp_rdata,
    output logic              disp_valid,
    output logic [SLOT_W-1:0] disp_slot,
    output logic [PH_W-1:0]   col_phase,
    output logic [COL_W-1:0]  col_idx,
    output logic              line_start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic video_req;
    logic cpu_grant;
    logic cpu_capture;

    vca_column_timer #(
        .COL_CLKS      (COL_CLKS),
        .COLS_PER_LINE (COLS_PER_LINE)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (col_phase),
        .col        (col_idx),
        .line_start (line_start)
    );

    vca_page_decode #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_decode (
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .page_sel  (page_sel),
        .video_req (video_req)
    );

    vca_cpu_gate #(
        .COL_CLKS     (COL_CLKS),
        .WIN_START    (WIN_START),
        .CPU_ACC_CLKS (CPU_ACC_CLKS)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (col_phase),
        .video_req (video_req),
        .grant     (cpu_grant),
        .capture   (cpu_capture),
        .clk_en    (cpu_clk_en)
    );

    vca_fetch_capture #(
        .COL_CLKS   (COL_CLKS),
        .FETCH_CLKS (FETCH_CLKS),
        .NUM_FETCH  (NUM_FETCH),
        .DATA_W     (DATA_W)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (col_phase),
        .mem_rdata  (mem_rdata),
        .disp_rdata (disp_rdata),
        .disp_valid (disp_valid),
        .disp_slot  (disp_slot)
    );

    // single memory port: the CPU only while granted, the display otherwise
    always_comb begin
        if (cpu_grant) begin
            mem_addr  = cpu_addr;
            mem_we    = cpu_we;
            mem_wdata = cpu_wdata;
        end else begin
            mem_addr  = disp_addr;
            mem_we    = 1'b0;
            mem_wdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (cpu_capture) begin
            cpu_rdata <= mem_rdata;
        end
    end

endmodule

// File: rtl/vca_checker.sv
module vca_checker #(
    parameter int COL_CLKS      = 16,
    parameter int FETCH_CLKS    = 5,
    parameter int NUM_FETCH     = 2,
    parameter int COLS_PER_LINE = 57,
    parameter int CPU_ACC_CLKS  = 3,
    parameter int ADDR_W        = 16,
    parameter int PAGE_W        = 2,
    localparam int PH_W   = $clog2(COL_CLKS),
    localparam int COL_W  = (COLS_PER_LINE > 1) ? $clog2(COLS_PER_LINE) : 1,
    localparam int NPAGES = 1 << PAGE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PH_W-1:0]   col_phase,
    input logic [COL_W-1:0]  col_idx,
    input logic              line_start,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [NPAGES-1:0] page_sel,
    input logic              cpu_clk_en,
    input logic              cpu_grant,
    input logic              mem_we,
    input logic              disp_valid
);

    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(COL_CLKS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS_PER_LINE - 1);
    localparam logic [PH_W-1:0]  WIN_S    = PH_W'(FETCH_CLKS * NUM_FETCH);
    localparam logic [PH_W-1:0]  LAST_S   = PH_W'(COL_CLKS - CPU_ACC_CLKS);

    logic [NUM_FETCH-1:0] at_end;
    for (genvar i = 0; i < NUM_FETCH; i++) begin : g_end
        assign at_end[i] = (col_phase == PH_W'((i + 1) * FETCH_CLKS - 1));
    end

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (col_phase == PH_LAST) |=> (col_phase == '0));

    p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (col_phase == PH_LAST && col_idx == COL_LAST) |=> line_start);

    p_valid_after_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $past(|at_end));

    p_we_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cpu_grant);

    p_nonvideo_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !page_sel[cpu_addr[ADDR_W-1 -: PAGE_W]] && !cpu_grant) |-> cpu_clk_en);

    p_frozen_in_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_grant |-> !cpu_clk_en);

    p_resume_after_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_grant) |-> cpu_clk_en);

    p_grant_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_grant |-> (col_phase >= WIN_S));

    p_start_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_grant) |-> (col_phase <= LAST_S));

endmodule

bind vram_contention_arbiter vca_checker #(
    .COL_CLKS      (COL_CLKS),
    .FETCH_CLKS    (FETCH_CLKS),
    .NUM_FETCH     (NUM_FETCH),
    .COLS_PER_LINE (COLS_PER_LINE),
    .CPU_ACC_CLKS  (CPU_ACC_CLKS),
    .ADDR_W        (ADDR_W),
    .PAGE_W        (PAGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .col_phase  (col_phase),
    .col_idx    (col_idx),
    .line_start (line_start),
    .cpu_req    (cpu_req),
    .cpu_addr   (cpu_addr),
    .page_sel   (page_sel),
    .cpu_clk_en (cpu_clk_en),
    .cpu_grant  (cpu_grant),
    .mem_we     (mem_we),
    .disp_valid (disp_valid)
);

// File: tb/vram_contention_arbiter_tb_top.sv
module vram_contention_arbiter_tb_top;

    localparam int COLS  = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        page_sel = 4'b0100;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_clk_en;
    logic [ADDR_W-1:0] disp_addr = 16'h8010;
    logic [DATA_W-1:0] disp_rdata;
    logic              disp_valid;
    logic [0:0]        disp_slot;
    logic [3:0]        col_phase;
    logic [1:0]        col_idx;
    logic              line_start;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    int  n_chk = 0;
    int  n_bad = 0;
    int  k = 0;
    bit  done = 1'b0;
    logic [7:0] bmem [256];

    always #5ns clk = ~clk;

    vram_contention_arbiter #(.COLS_PER_LINE(COLS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_sel   (page_sel),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_clk_en (cpu_clk_en),
        .disp_addr  (disp_addr),
        .disp_rdata (disp_rdata),
        .disp_valid (disp_valid),
        .disp_slot  (disp_slot),
        .col_phase  (col_phase),
        .col_idx    (col_idx),
        .line_start (line_start),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [7:0] a);
        return 8'(int'(a) * 7 + 3);
    endfunction

    // small memory model keyed by the low address byte
    assign mem_rdata = bmem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= pat(8'(i));
        end else if (mem_we) begin
            bmem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    // bench's own count of clocks since reset: phase = k % 16
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_phase(input int p);
        @(negedge clk);
        while ((k % 16) != p) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        check("R9 phase after reset", int'(col_phase), 0);
        check("R9 column after reset", int'(col_idx), 0);
        check("R9 line_start after reset", int'(line_start), 1);
        check("R9 disp_valid after reset", int'(disp_valid), 0);
        check("R9 clk_en after reset", int'(cpu_clk_en), 1);
    endtask

    task automatic t_timing();
        int bad_ph = 0;
        int bad_col = 0;
        int bad_ls = 0;
        for (int n = 0; n < 3 * 16 * COLS; n++) begin
            @(negedge clk); #1;
            if (int'(col_phase) != k % 16) bad_ph++;
            if (int'(col_idx) != (k / 16) % COLS) bad_col++;
            if (int'(line_start) != ((k % (16 * COLS)) == 0 ? 1 : 0)) bad_ls++;
        end
        check("R1 phase mismatches", bad_ph, 0);
        check("R1 column mismatches", bad_col, 0);
        check("R1 line_start mismatches", bad_ls, 0);
    endtask

    task automatic t_fetch();
        wait_phase(0);
        disp_addr = 16'h8010;
        @(negedge clk); @(negedge clk); #1;
        check("R2 mem_addr in fetch slot 0", int'(mem_addr), 16'h8010);
        check("R2 mem_we in fetch slot 0", int'(mem_we), 0);
        wait_phase(5);
        disp_addr = 16'h8020;
        #1;
        check("R3 disp_valid at phase 5", int'(disp_valid), 1);
        check("R3 disp_rdata slot 0", int'(disp_rdata), int'(pat(8'h10)));
        check("R3 disp_slot 0", int'(disp_slot), 0);
        @(negedge clk); #1;
        check("R3 disp_valid low at phase 6", int'(disp_valid), 0);
        check("R2 mem_addr in fetch slot 1", int'(mem_addr), 16'h8020);
        wait_phase(10); #1;
        check("R3 disp_valid at phase 10", int'(disp_valid), 1);
        check("R3 disp_rdata slot 1", int'(disp_rdata), int'(pat(8'h20)));
        check("R3 disp_slot 1", int'(disp_slot), 1);
    endtask

    task automatic cpu_xfer(input string tag, input int p, input logic [15:0] a,
                            input logic we, input logic [7:0] wd,
                            input int exp_stall, input int exp_rd);
        int stall = 0;
        int bad_port = 0;
        wait_phase(p);
        cpu_addr  = a;
        cpu_we    = we;
        cpu_wdata = wd;
        cpu_req   = 1'b1;
        forever begin
            #1;
            if (cpu_clk_en || stall > 100) break;
            if (stall >= exp_stall - 3) begin
                if (mem_addr != a || mem_we != we) bad_port++;
                if (we && mem_wdata != wd) bad_port++;
            end else if (mem_we) begin
                bad_port++;
            end
            stall++;
            @(negedge clk);
        end
        check({tag, " R6 R8 stall cycles"}, stall, exp_stall);
        check({tag, " R7 port ownership during access"}, bad_port, 0);
        check({tag, " R7 release phase"}, k % 16, (p + exp_stall) % 16);
        if (!we) check({tag, " R7 read data"}, int'(cpu_rdata), exp_rd);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
    endtask

    task automatic t_nonvideo(input string tag, input logic [15:0] a);
        int bad = 0;
        wait_phase(3);
        cpu_addr = a;
        cpu_req  = 1'b1;
        for (int n = 0; n < 20; n++) begin
            #1;
            if (!cpu_clk_en || mem_we || mem_addr != disp_addr) bad++;
            @(negedge clk);
        end
        cpu_req = 1'b0;
        check({tag, " R4 R5 non-video request never stalls"}, bad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_fetch();
        cpu_xfer("early",    2,  16'h8031, 1'b0, 8'h00, 11, int'(pat(8'h31)));
        cpu_xfer("ph9",      9,  16'h8032, 1'b0, 8'h00, 4,  int'(pat(8'h32)));
        cpu_xfer("ph11",     11, 16'h8033, 1'b0, 8'h00, 4,  int'(pat(8'h33)));
        cpu_xfer("laststart",12, 16'h8034, 1'b0, 8'h00, 4,  int'(pat(8'h34)));
        cpu_xfer("defer13",  13, 16'h8035, 1'b0, 8'h00, 16, int'(pat(8'h35)));
        cpu_xfer("defer15",  15, 16'h8036, 1'b0, 8'h00, 14, int'(pat(8'h36)));
        cpu_xfer("write",    5,  16'h80A0, 1'b1, 8'h5A, 8,  0);
        cpu_xfer("readback", 10, 16'h80A0, 1'b0, 8'h00, 4,  8'h5A);
        t_nonvideo("page0", 16'h0044);
        page_sel = 4'b0001;
        cpu_xfer("remap", 2, 16'h0044, 1'b0, 8'h00, 11, int'(pat(8'h44)));
        t_nonvideo("page2 freed", 16'h8044);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule